// File: doc/BRIEF.md
# Body Diode Bypass Controller

This block watches a series pair of charge and discharge FET drivers. Sometimes the normal control logic has one FET switched on and the other switched off. Current then has to pass through the body diode of the FET that is off. When the measured current is large enough in either direction, the block raises a bypass request that switches the off FET on. The driver stage ORs this request with its normal enable. This takes the dissipation off the diode.

Current is judged by its magnitude against an unsigned threshold. The magnitude of the most negative code saturates to the largest positive code. A new decision is taken only on cycles that carry a valid current sample. When the current-converter mode field selects the powered-down converter, the current path is not used. The wake comparator flag decides instead, and it is looked at on every cycle.

A request, once raised, is held for at least a programmable number of 1 ms ticks (240 by default). This stops the driver from chattering when the current sits near the threshold. A fault shutdown, a host manual-off for that FET, or clearing the series-configuration bit removes the request at once, whether or not the hold time has passed.

Top module: `fet_bypass_guard`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both bypass requests (`chg_assist_o`, `dsg_assist_o`) are 0.
- R2: With `series_en_i`=1, exactly one of `chg_cmd_i`/`dsg_cmd_i` at 1, and a valid sample whose magnitude exceeds `thr_i`, the request for the commanded-off FET goes to 1 at the clock edge that takes the sample.
- R3: The magnitude of a negative current is its absolute value. The most negative code (0x8000 at 16 bits) is treated as 32767, so it does not exceed a threshold of 32767 but does exceed 32766.
- R4: The compare is strictly greater than: a magnitude equal to `thr_i` does not raise a request.
- R5: On cycles where `cur_vld_i`=0, the current value is ignored and no decision changes (except those made in the mode of R6).
- R6: When `cc_mode_i`=3, `wake_i` replaces the current compare and is evaluated every clock. Current, valid strobe and threshold have no effect. In any other mode `wake_i` has no effect.
- R7: With `series_en_i`=0, no request is raised, and any active request drops at the next edge.
- R8: When both FETs are commanded on, or both are commanded off, no request is raised.
- R9: A raised request stays at 1 for at least `HOLD_TICKS` ticks of `tick_i`, even if the trigger condition goes false. The tick count starts from the edge that raised it. Faults and manual-off (R11) and R7 are the exceptions.
- R10: After the hold has expired, the request drops at the first evaluated sample whose trigger condition is false. It stays at 1 while no sample is evaluated, and while evaluated samples still meet the trigger.
- R11: A fault-off or manual-off input for a FET clears that FET's request at the next edge, bypassing the hold time. While that input is high, the request cannot be raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cur_i | input | CUR_W | Calibrated signed current sample |
| cur_vld_i | input | 1 | Current sample valid strobe |
| thr_i | input | CUR_W | Unsigned magnitude threshold |
| wake_i | input | 1 | Wake comparator flag |
| cc_mode_i | input | 2 | Current-converter mode; 3 = converter off |
| series_en_i | input | 1 | Series-FET configuration enable |
| chg_cmd_i | input | 1 | Charge FET commanded on by normal control |
| dsg_cmd_i | input | 1 | Discharge FET commanded on by normal control |
| chg_fault_off_i | input | 1 | Fault shutdown request for the charge FET |
| dsg_fault_off_i | input | 1 | Fault shutdown request for the discharge FET |
| chg_man_off_i | input | 1 | Host manual-off for the charge FET |
| dsg_man_off_i | input | 1 | Host manual-off for the discharge FET |
| tick_i | input | 1 | One-cycle 1 ms tick pulse |
| chg_assist_o | output | 1 | Bypass request: switch the charge FET on |
| dsg_assist_o | output | 1 | Bypass request: switch the discharge FET on |

## Verification
The properties assume that reset is held low for at least one rising edge. They assume that every input is a known level sampled at the edge. They assume that fault and manual-off requests last whole cycles, and that `tick_i` is a single-cycle pulse. The stimulus changes inputs only a short delay after a rising edge and keeps each value for a whole cycle. During the hold tests the tick is driven high on every cycle, so the hold window closes at a known edge. The checker keeps its own tick count from each rising request and needs no deep history.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

   localparam int unsigned FET_N   = 2;
   localparam int unsigned CHG_IDX = 0;
   localparam int unsigned DSG_IDX = 1;

   typedef enum logic [1:0] {
      CC_FULL   = 2'd0,
      CC_SLOTS  = 2'd1,
      CC_LOWPWR = 2'd2,
      CC_OFF    = 2'd3
   } cc_mode_e;

endpackage

// File: rtl/fbg_cur_mag.sv
// Magnitude of a signed current sample; variant chosen by SAT_ABS.
module fbg_cur_mag #(
   parameter int unsigned W       = 16,
   parameter bit          SAT_ABS = 1'b1
) (
   input  logic signed [W-1:0] val_i,
   output logic        [W-1:0] mag_o
);

   logic [W-1:0] neg;
   logic         is_min;

   assign neg    = -val_i;
   assign is_min = val_i[W-1] && (val_i[W-2:0] == '0);

   generate
      if (SAT_ABS) begin : g_sat
         // R3: most negative code folds onto the largest positive code
         localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
         always_comb begin
            if (is_min)          mag_o = MAX_POS;
            else if (val_i[W-1]) mag_o = neg;
            else                 mag_o = val_i;
         end
      end else begin : g_exact
         // unsigned wrap of the negation is the exact magnitude
         always_comb begin
            mag_o = val_i[W-1] ? neg : val_i;
            if (is_min) mag_o = {1'b1, {(W-1){1'b0}}};
         end
      end
   endgenerate

endmodule

// File: rtl/fbg_need_src.sv
// Selects the decision source and says when a decision is taken.
module fbg_need_src
   import fbg_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] mag_i,
   input  logic [W-1:0] thr_i,
   input  logic         vld_i,
   input  logic         wake_i,
   input  logic [1:0]   mode_i,
   output logic         eval_o,
   output logic         over_o
);

   logic wake_sel;

   assign wake_sel = (cc_mode_e'(mode_i) == CC_OFF);

   always_comb begin
      if (wake_sel) begin
         eval_o = 1'b1;       // R6: flag looked at every clock
         over_o = wake_i;
      end else begin
         eval_o = vld_i;      // R5: only valid samples count
         over_o = (mag_i > thr_i);  // R4: strictly greater
      end
   end

endmodule

// File: rtl/fbg_assist_leg.sv
// One FET's bypass request with minimum-on hold.
module fbg_assist_leg #(
   parameter int unsigned HOLD_TICKS = 240
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic eval_i,
   input  logic want_i,
   input  logic kill_i,
   input  logic tick_i,
   output logic assist_o
);

   localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
   localparam logic [CW-1:0] HOLD_END = CW'(HOLD_TICKS);

   logic          act_q;
   logic [CW-1:0] cnt_q;
   logic          expired;

   assign expired  = (cnt_q == HOLD_END);
   assign assist_o = act_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (kill_i) begin
         act_q <= 1'b0;           // R11/R7: immediate release
         cnt_q <= '0;
      end else if (!act_q) begin
         if (eval_i && want_i) begin
            act_q <= 1'b1;        // R2
            cnt_q <= '0;
         end
      end else if (expired) begin
         if (eval_i && !want_i) act_q <= 1'b0;   // R10
      end else if (tick_i) begin
         cnt_q <= cnt_q + CW'(1); // R9
      end
   end

endmodule

// File: rtl/fet_bypass_guard.sv
module fet_bypass_guard
   import fbg_pkg::*;
#(
   parameter int unsigned CUR_W      = 16,
   parameter int unsigned HOLD_TICKS = 240,
   parameter bit          SAT_ABS    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic signed [CUR_W-1:0] cur_i,
   input  logic              cur_vld_i,
   input  logic [CUR_W-1:0]  thr_i,
   input  logic              wake_i,
   input  logic [1:0]        cc_mode_i,
   input  logic              series_en_i,
   input  logic              chg_cmd_i,
   input  logic              dsg_cmd_i,
   input  logic              chg_fault_off_i,
   input  logic              dsg_fault_off_i,
   input  logic              chg_man_off_i,
   input  logic              dsg_man_off_i,
   input  logic              tick_i,
   output logic              chg_assist_o,
   output logic              dsg_assist_o
);

   generate
      if (CUR_W < 2) begin : g_bad_width
         $error("fet_bypass_guard: CUR_W must be at least 2");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("fet_bypass_guard: HOLD_TICKS must be at least 1");
      end
   endgenerate

   logic [CUR_W-1:0] mag;
   logic             eval;
   logic             over;
   logic [FET_N-1:0] fet_cmd;
   logic [FET_N-1:0] fet_kill;
   logic [FET_N-1:0] assist;

   fbg_cur_mag #(.W(CUR_W), .SAT_ABS(SAT_ABS)) u_mag (
      .val_i (cur_i),
      .mag_o (mag)
   );

   fbg_need_src #(.W(CUR_W)) u_src (
      .mag_i  (mag),
      .thr_i  (thr_i),
      .vld_i  (cur_vld_i),
      .wake_i (wake_i),
      .mode_i (cc_mode_i),
      .eval_o (eval),
      .over_o (over)
   );

   assign fet_cmd[CHG_IDX]  = chg_cmd_i;
   assign fet_cmd[DSG_IDX]  = dsg_cmd_i;
   assign fet_kill[CHG_IDX] = chg_fault_off_i | chg_man_off_i | ~series_en_i;
   assign fet_kill[DSG_IDX] = dsg_fault_off_i | dsg_man_off_i | ~series_en_i;

   generate
      for (genvar g = 0; g < FET_N; g++) begin : g_leg
         logic want;
         // R8: exactly one FET commanded on, this one off
         assign want = series_en_i & fet_cmd[FET_N-1-g] & ~fet_cmd[g] & over;

         fbg_assist_leg #(.HOLD_TICKS(HOLD_TICKS)) u_leg (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .eval_i   (eval),
            .want_i   (want),
            .kill_i   (fet_kill[g]),
            .tick_i   (tick_i),
            .assist_o (assist[g])
         );
      end
   endgenerate

   assign chg_assist_o = assist[CHG_IDX];
   assign dsg_assist_o = assist[DSG_IDX];

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
   parameter int unsigned HOLD_TICKS = 240
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       cur_vld_i,
   input logic [1:0] cc_mode_i,
   input logic       series_en_i,
   input logic       chg_cmd_i,
   input logic       dsg_cmd_i,
   input logic       chg_fault_off_i,
   input logic       dsg_fault_off_i,
   input logic       chg_man_off_i,
   input logic       dsg_man_off_i,
   input logic       tick_i,
   input logic       chg_assist_o,
   input logic       dsg_assist_o
);

   localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
   localparam logic [CW-1:0] HOLD_END = CW'(HOLD_TICKS);

   logic [CW-1:0] on_ticks_c;
   logic [CW-1:0] on_ticks_d;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !chg_assist_o)                on_ticks_c <= '0;
      else if (tick_i && on_ticks_c != HOLD_END)   on_ticks_c <= on_ticks_c + CW'(1);
      if (!rst_ni || !dsg_assist_o)                on_ticks_d <= '0;
      else if (tick_i && on_ticks_d != HOLD_END)   on_ticks_d <= on_ticks_d + CW'(1);
   end

   a_r11_chg_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chg_fault_off_i || chg_man_off_i) |=> !chg_assist_o);

   a_r11_dsg_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dsg_fault_off_i || dsg_man_off_i) |=> !dsg_assist_o);

   a_r7_series_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !series_en_i |=> !(chg_assist_o || dsg_assist_o));

   a_r2_chg_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chg_assist_o) |-> $past(dsg_cmd_i && !chg_cmd_i && series_en_i));

   a_r2_dsg_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dsg_assist_o) |-> $past(chg_cmd_i && !dsg_cmd_i && series_en_i));

   a_r5_needs_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(dsg_assist_o) || $rose(chg_assist_o)) |->
         $past(cur_vld_i || cc_mode_i == 2'd3));

   a_r9_chg_min_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(chg_assist_o) &&
       !$past(chg_fault_off_i || chg_man_off_i || !series_en_i))
         |-> (on_ticks_c == HOLD_END));

   a_r9_dsg_min_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(dsg_assist_o) &&
       !$past(dsg_fault_off_i || dsg_man_off_i || !series_en_i))
         |-> (on_ticks_d == HOLD_END));

endmodule

bind fet_bypass_guard fbg_checker #(.HOLD_TICKS(HOLD_TICKS)) u_fbg_checker (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .cur_vld_i       (cur_vld_i),
   .cc_mode_i       (cc_mode_i),
   .series_en_i     (series_en_i),
   .chg_cmd_i       (chg_cmd_i),
   .dsg_cmd_i       (dsg_cmd_i),
   .chg_fault_off_i (chg_fault_off_i),
   .dsg_fault_off_i (dsg_fault_off_i),
   .chg_man_off_i   (chg_man_off_i),
   .dsg_man_off_i   (dsg_man_off_i),
   .tick_i          (tick_i),
   .chg_assist_o    (chg_assist_o),
   .dsg_assist_o    (dsg_assist_o)
);

// File: tb/fet_bypass_guard_bench.sv
module fet_bypass_guard_bench;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned CUR_W      = 16;
   localparam int unsigned HOLD_TICKS = 240;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [CUR_W-1:0] cur = '0;
   logic cur_vld = 1'b0;
   logic [CUR_W-1:0] thr = 16'd100;
   logic wake = 1'b0;
   logic [1:0] cc_mode = 2'd0;
   logic series_en = 1'b0;
   logic chg_cmd = 1'b0, dsg_cmd = 1'b0;
   logic chg_flt = 1'b0, dsg_flt = 1'b0;
   logic chg_man = 1'b0, dsg_man = 1'b0;
   logic tick = 1'b0;
   logic chg_as, dsg_as;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   fet_bypass_guard #(.CUR_W(CUR_W), .HOLD_TICKS(HOLD_TICKS)) u_fet_bypass_guard (
      .clk_i (clk), .rst_ni (rst_n), .cur_i (cur), .cur_vld_i (cur_vld),
      .thr_i (thr), .wake_i (wake), .cc_mode_i (cc_mode),
      .series_en_i (series_en), .chg_cmd_i (chg_cmd), .dsg_cmd_i (dsg_cmd),
      .chg_fault_off_i (chg_flt), .dsg_fault_off_i (dsg_flt),
      .chg_man_off_i (chg_man), .dsg_man_off_i (dsg_man), .tick_i (tick),
      .chg_assist_o (chg_as), .dsg_assist_o (dsg_as)
   );

   // driver: lets one edge pass, then queues the expected outputs
   task automatic cyc(input bit ec, input bit ed, input string tag);
      @(posedge clk);
      #1;
      exp_q.push_back({ec, ed});
      tag_q.push_back(tag);
   endtask

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({chg_as, dsg_as} !== e) begin
            fails++;
            $display("FAIL %s: chg/dsg assist actual=%b%b expected=%b%b at %0t",
                     t, chg_as, dsg_as, e[1], e[0], $time);
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (R1..): actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cyc(0, 0, "R1");
      cyc(0, 0, "R1");
      rst_n = 1'b1;
      cyc(0, 0, "R1");

      // R5: samples without strobe ignored
      series_en = 1; chg_cmd = 1; dsg_cmd = 0; cur = 16'sd500; cur_vld = 0;
      for (int i = 0; i < 3; i++) cyc(0, 0, "R5");

      // R2: discharge FET bypassed
      cur_vld = 1;
      cyc(0, 1, "R2");

      // R11: fault bypasses hold, blocks re-raise
      dsg_flt = 1;
      cyc(0, 0, "R11");
      cyc(0, 0, "R11");
      dsg_flt = 0;
      cyc(0, 1, "R2");
      dsg_man = 1;
      cyc(0, 0, "R11");
      dsg_man = 0; series_en = 0;
      cyc(0, 0, "R7");
      cyc(0, 0, "R7");

      // R4: equality does not trigger
      cur_vld = 0; series_en = 1;
      cyc(0, 0, "R5");
      cur_vld = 1; cur = 16'sd100; thr = 16'd100;
      cyc(0, 0, "R4");
      cur = 16'sd101;
      cyc(0, 1, "R4");
      series_en = 0;
      cyc(0, 0, "R7");

      // R3: negative currents, charge FET bypassed
      series_en = 1; chg_cmd = 0; dsg_cmd = 1; cur = -16'sd500;
      cyc(1, 0, "R3");
      chg_man = 1;
      cyc(0, 0, "R11");
      chg_man = 0; cur = 16'sh8000; thr = 16'd32767;
      cyc(0, 0, "R3");
      thr = 16'd32766;
      cyc(1, 0, "R3");
      series_en = 0;
      cyc(0, 0, "R7");

      // R8: both on / both off
      series_en = 1; thr = 16'd100; cur = 16'sd500;
      chg_cmd = 1; dsg_cmd = 1;
      cyc(0, 0, "R8");
      chg_cmd = 0; dsg_cmd = 0;
      cyc(0, 0, "R8");

      // R6: wake flag source
      chg_cmd = 1; cc_mode = 2'd3; cur = 16'sd5000; wake = 0;
      cyc(0, 0, "R6");
      cur_vld = 0; cur = 16'sd0; wake = 1;
      cyc(0, 1, "R6");
      series_en = 0;
      cyc(0, 0, "R7");
      series_en = 1; cc_mode = 2'd2; cur_vld = 1;
      cyc(0, 0, "R6");
      wake = 0; cc_mode = 2'd0;

      // R9 then R10 with evaluated samples
      cur = 16'sd500;
      cyc(0, 1, "R2");
      cur = 16'sd0; tick = 1;
      for (int i = 0; i < HOLD_TICKS; i++) cyc(0, 1, "R9");
      cyc(0, 0, "R10");

      // R9 then R10 with strobe low after expiry
      tick = 0; cur = 16'sd500;
      cyc(0, 1, "R2");
      cur_vld = 0; cur = 16'sd0; tick = 1;
      for (int i = 0; i < HOLD_TICKS; i++) cyc(0, 1, "R9");
      for (int i = 0; i < 3; i++) cyc(0, 1, "R10");
      cur_vld = 1; cur = 16'sd500;
      cyc(0, 1, "R10");
      cur = 16'sd0;
      cyc(0, 0, "R10");
      tick = 0;

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule